// File: doc/BRIEF.md
# Decimating FIR Multiply-Accumulate Cell

This block is one tap of a systolic FIR filter. Every clock it multiplies a registered signed 8-bit coefficient by a registered signed 8-bit data sample. It adds the product, sign-extended, into a 26-bit accumulator that wraps on overflow. A long filter is built by chaining cells: the coefficient output of one cell drives the coefficient input of the next.

On its way to the output, the coefficient can pass through up to three extra decimation registers. A 2-bit code picks how many, so the coefficient takes one to four loads to move from one cell to the next. Changing the code at run time lets the same chain of cells implement a decimating filter. Both the input register and the decimation registers advance only while the active-low load enable is asserted.

The general reset clears the coefficient path, the data register and the latched code. It does not clear the accumulator. The accumulator has its own synchronous clear.

Top module: `fir_tap_cell`

## Requirements
- R1: On every rising edge with `acc_clr_n` high, `acc_out` becomes its previous value plus the signed product of the coefficient register and the data register. The data register holds the `data_in` sample taken at the previous edge, and both operands are two's complement.
- R2: With latched code 0, `coef_out` shows the coefficient loaded at the most recent enabled edge.
- R3: With latched code 1, 2 or 3, `coef_out` shows the coefficient loaded 1, 2 or 3 enabled edges before the most recent one. Each enabled edge shifts the whole chain by one place.
- R4: While `coef_en_n` is high, the coefficient register and all decimation registers keep their values, so `coef_out` is stable while the latched code is unchanged.
- R5: `dec_sel` is registered at each edge, and the registered code steers `coef_out` only after that edge. A new code therefore takes effect one clock after it is applied.
- R6: `rst_n` low at an edge clears the coefficient register, the decimation registers, the data register and the latched code, so `coef_out` reads 0 afterwards.
- R7: `acc_clr_n` low at an edge makes `acc_out` 0, whatever the state of `rst_n`. `rst_n` alone leaves the accumulator updating as in R1.
- R8: The accumulator sum wraps modulo 2^26 on overflow in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the coefficient path, data register and code |
| coef_en_n | input | 1 | Active-low load enable for the coefficient and decimation registers |
| acc_clr_n | input | 1 | Synchronous active-low accumulator clear |
| dec_sel | input | 2 | Decimation code: number of extra coefficient registers (0 to 3) |
| coef_in | input | 8 | Signed coefficient from the previous cell or a source |
| data_in | input | 8 | Signed data sample |
| coef_out | output | 8 | Forwarded coefficient for the next cell |
| acc_out | output | 26 | Accumulator value |

## Verification
The accumulator has no reset, so the accumulation property holds only after a clear has been seen. The checker tracks this with its own flag, and the stimulus always asserts `acc_clr_n` before it relies on the accumulator. The hold property expects the latched code to stay unchanged. The stimulus changes `dec_sel` during bursts with the enable both high and low, so both the hold case and the code change are exercised. A long run at the most negative operands drives the sum across the 26-bit limit.

// File: rtl/fir_cell_pkg.sv
package fir_cell_pkg;
  localparam int CELL_COEF_W  = 8;
  localparam int CELL_DATA_W  = 8;
  localparam int CELL_ACC_W   = 26;
  localparam int CELL_DEC_MAX = 3;

  typedef enum logic [1:0] {
    DEC_NONE  = 2'd0,
    DEC_ONE   = 2'd1,
    DEC_TWO   = 2'd2,
    DEC_THREE = 2'd3
  } dec_code_e;
endpackage

// File: rtl/fir_coef_pipe.sv
module fir_coef_pipe #(
  parameter int W     = 8,
  parameter int DEPTH = 3,
  parameter int SEL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEL_W-1:0] sel_in,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     c_q,
  output logic [SEL_W-1:0] sel_q,
  output logic [W-1:0]     dout
);
  logic [W-1:0] stage [0:DEPTH];

  // input (coefficient) register
  always_ff @(posedge clk) begin
    if (!rst_n)    stage[0] <= '0;
    else if (load) stage[0] <= din;
  end

  // decimation chain
  for (genvar i = 1; i <= DEPTH; i++) begin : g_dec
    always_ff @(posedge clk) begin
      if (!rst_n)    stage[i] <= '0;
      else if (load) stage[i] <= stage[i-1];
    end
  end

  // code is latched, effective one clock later
  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_in;
  end

  assign c_q  = stage[0];
  assign dout = (sel_q > SEL_W'(DEPTH)) ? stage[DEPTH] : stage[sel_q];
endmodule

// File: rtl/fir_mac_acc.sv
module fir_mac_acc #(
  parameter int CW = 8,
  parameter int DW = 8,
  parameter int AW = 26,
  localparam int PW = CW + DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [CW-1:0] c_op,
  input  logic [DW-1:0] d_in,
  output logic [PW-1:0] prod_o,
  output logic [AW-1:0] acc_o
);
  logic [DW-1:0] x_q;
  logic [AW-1:0] acc_q;

  function automatic logic [PW-1:0] smul(logic [CW-1:0] a, logic [DW-1:0] b);
    logic signed [PW-1:0] r;
    r = $signed({{DW{a[CW-1]}}, a}) * $signed({{CW{b[DW-1]}}, b});
    return r;
  endfunction

  function automatic logic [AW-1:0] wrap_add(logic [AW-1:0] a, logic [PW-1:0] p);
    return a + {{(AW-PW){p[PW-1]}}, p};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) x_q <= '0;
    else        x_q <= d_in;
  end

  assign prod_o = smul(c_op, x_q);

  always_ff @(posedge clk) begin
    if (clear) acc_q <= '0;
    else       acc_q <= wrap_add(acc_q, prod_o);
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/fir_tap_cell.sv
module fir_tap_cell
  import fir_cell_pkg::*;
#(
  parameter int COEF_W  = CELL_COEF_W,
  parameter int DATA_W  = CELL_DATA_W,
  parameter int ACC_W   = CELL_ACC_W,
  parameter int DEC_MAX = CELL_DEC_MAX,
  localparam int SEL_W  = $clog2(DEC_MAX + 1),
  localparam int PROD_W = COEF_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              coef_en_n,
  input  logic              acc_clr_n,
  input  logic [SEL_W-1:0]  dec_sel,
  input  logic [COEF_W-1:0] coef_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [COEF_W-1:0] coef_out,
  output logic [ACC_W-1:0]  acc_out
);
  // named internal events
  logic              coef_load;
  logic              acc_clear;
  logic [COEF_W-1:0] c_cur;
  logic [SEL_W-1:0]  dec_q;
  logic [PROD_W-1:0] product;

  assign coef_load = ~coef_en_n;
  assign acc_clear = ~acc_clr_n;

  fir_coef_pipe #(.W(COEF_W), .DEPTH(DEC_MAX), .SEL_W(SEL_W)) u_pipe (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (coef_load),
    .sel_in (dec_sel),
    .din    (coef_in),
    .c_q    (c_cur),
    .sel_q  (dec_q),
    .dout   (coef_out)
  );

  fir_mac_acc #(.CW(COEF_W), .DW(DATA_W), .AW(ACC_W)) u_mac (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (acc_clear),
    .c_op   (c_cur),
    .d_in   (data_in),
    .prod_o (product),
    .acc_o  (acc_out)
  );
endmodule

// File: rtl/fir_tap_cell_chk.sv
module fir_tap_cell_chk #(
  parameter int COEF_W = 8,
  parameter int ACC_W  = 26,
  parameter int SEL_W  = 2,
  parameter int PROD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              coef_load,
  input logic              acc_clear,
  input logic [SEL_W-1:0]  dec_sel,
  input logic [SEL_W-1:0]  dec_q,
  input logic [COEF_W-1:0] coef_in,
  input logic [COEF_W-1:0] coef_out,
  input logic [PROD_W-1:0] product,
  input logic [ACC_W-1:0]  acc_out
);
  logic past_ok   = 1'b0;
  logic acc_known = 1'b0;

  always_ff @(posedge clk) begin
    past_ok <= 1'b1;
    if (acc_clear) acc_known <= 1'b1;
  end

  a_r1_mac_step: assert property (@(posedge clk) disable iff (!past_ok)
    (acc_known && $past(acc_known) && !$past(acc_clear)) |->
      acc_out == $past(acc_out) + {{(ACC_W-PROD_W){$past(product[PROD_W-1])}}, $past(product)});

  a_r7_clear: assert property (@(posedge clk) disable iff (!past_ok)
    $past(acc_clear) |-> acc_out == '0);

  a_r2_direct: assert property (@(posedge clk) disable iff (!past_ok || !rst_n)
    ($past(rst_n) && $past(coef_load) && dec_q == '0) |-> coef_out == $past(coef_in));

  a_r4_hold: assert property (@(posedge clk) disable iff (!past_ok || !rst_n)
    ($past(rst_n) && !$past(coef_load) && $stable(dec_q)) |-> $stable(coef_out));

  a_r5_code_latch: assert property (@(posedge clk) disable iff (!past_ok || !rst_n)
    $past(rst_n) |-> dec_q == $past(dec_sel));

  a_r6_reset: assert property (@(posedge clk) disable iff (!past_ok)
    !$past(rst_n) |-> (coef_out == '0 && dec_q == '0));
endmodule

bind fir_tap_cell fir_tap_cell_chk #(
  .COEF_W(COEF_W), .ACC_W(ACC_W), .SEL_W(SEL_W), .PROD_W(PROD_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .coef_load (coef_load),
  .acc_clear (acc_clear),
  .dec_sel   (dec_sel),
  .dec_q     (dec_q),
  .coef_in   (coef_in),
  .coef_out  (coef_out),
  .product   (product),
  .acc_out   (acc_out)
);

// File: tb/fir_tap_cell_tb.sv
`timescale 1ns/1ps
module fir_tap_cell_tb;
  logic        clk = 1'b0;
  logic        rst_n, coef_en_n, acc_clr_n;
  logic [1:0]  dec_sel;
  logic [7:0]  coef_in, data_in;
  logic [7:0]  coef_out;
  logic [25:0] acc_out;

  always #5 clk = ~clk;

  fir_tap_cell u_dut (
    .clk(clk), .rst_n(rst_n), .coef_en_n(coef_en_n), .acc_clr_n(acc_clr_n),
    .dec_sel(dec_sel), .coef_in(coef_in), .data_in(data_in),
    .coef_out(coef_out), .acc_out(acc_out)
  );

  // behavioural reference
  logic [7:0]  hist[$];   // loaded coefficients, newest first
  logic [7:0]  m_x;
  int          m_dec;
  logic [25:0] m_acc;
  bit          acc_valid;
  int          checks = 0, fails = 0;
  bit          done = 0;

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    hist.delete();
    for (int i = 0; i < 4; i++) hist.push_back(8'd0);
    m_x = 0; m_dec = 0;
  endtask

  // one clock: apply inputs, advance model, compare away from edge
  task automatic step(bit r, bit en, bit clr, int dsel, int c, int d);
    int    prev_dec;
    int    p;
    string tag_c;
    rst_n = r; coef_en_n = en; acc_clr_n = clr;
    dec_sel = 2'(dsel); coef_in = 8'(c); data_in = 8'(d);
    @(posedge clk);
    prev_dec = m_dec;
    p = int'($signed(hist[0])) * int'($signed(m_x));
    if (!clr) begin m_acc = '0; acc_valid = 1; end
    else m_acc = m_acc + 26'(p);
    if (!r) model_reset();
    else begin
      m_dec = dsel;
      if (!en) begin hist.push_front(8'(c)); void'(hist.pop_back()); end
      m_x = 8'(d);
    end
    #2;
    if (!r)                 tag_c = "R6";
    else if (m_dec != prev_dec) tag_c = "R5";
    else if (en)            tag_c = "R4";
    else if (m_dec == 0)    tag_c = "R2";
    else                    tag_c = "R3";
    check(coef_out === hist[m_dec], tag_c, coef_out, hist[m_dec]);
    if (acc_valid)
      check(acc_out === m_acc, !clr ? "R7" : "R1", acc_out, m_acc);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    model_reset(); m_acc = '0; acc_valid = 0;
    // R6: reset and R7: clear
    step(0, 1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0);
    check(coef_out === 8'd0, "R6", coef_out, 0);
    check(acc_out === 26'd0, "R7", acc_out, 0);
    // R2/R3/R1: all four codes, enable mostly asserted
    for (int dm = 0; dm < 4; dm++) begin
      for (int k = 0; k < 40; k++)
        step(1, (k % 7 == 5), 1, dm, $urandom_range(0, 255), $urandom_range(0, 255));
    end
    // R5/R4: code changes with enable high and low
    for (int k = 0; k < 60; k++)
      step(1, (k % 3 == 0), 1, $urandom_range(0, 3), $urandom_range(0, 255), $urandom_range(0, 255));
    // R4: long hold with fixed code
    for (int k = 0; k < 10; k++) step(1, 1, 1, 2, k * 13, k);
    // R7: reset mid-run leaves accumulator running
    step(1, 0, 1, 3, 100, 50);
    step(1, 0, 1, 3, 90, 40);
    step(0, 0, 1, 3, 77, 33);
    check(coef_out === 8'd0, "R6", coef_out, 0);
    check(acc_out === m_acc && m_acc != 0, "R7", acc_out, m_acc);
    // R7: clear with reset simultaneously
    step(0, 0, 0, 0, 0, 0);
    check(acc_out === 26'd0, "R7", acc_out, 0);
    // R8: positive overflow with (-128)*(-128)
    for (int k = 0; k < 2100; k++) step(1, 0, 1, 0, -128, -128);
    check(acc_out === m_acc && m_acc < 26'd2100 * 16384, "R8", acc_out, m_acc);
    // R8: negative wrap with (-128)*127
    step(1, 0, 0, 0, -128, 127);
    for (int k = 0; k < 40; k++) step(1, 0, 1, 0, -128, 127);
    check(acc_out === m_acc && acc_out[25], "R8", acc_out, m_acc);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule